// File: doc/BRIEF.md
# Source and Destination Pixel Address Counters

This block supplies the pixel addresses for incremental drawing routines on a 2048 by 2048 pixel display memory. It has two coordinate units, one for the source and one for the destination of an area copy, each with an X and a Y register. Microcode loads any coordinate from a shared 16-bit bus. On each step cycle it then tells every axis separately to move up by one, move down by one or stay where it is. Each unit's coordinates are combined into a 22-bit linear address, with Y as the upper half and X as the lower half.

A transfer counter is loaded with the number of steps that the current primitive needs. Each step cycle consumes one count. When the count is exhausted, a done flag rises and freezes all four axes until the counter is loaded again. The microcode sequencer can branch on this flag to end the algorithm. Every coordinate and the counter can be driven back onto an output bus for inspection.

Top module: `xy_pixel_addr_gen`

## Requirements
- R1: After reset, all four coordinates and the step count are 0, so both addresses are 0 and `done` is 1.
- R2: When `ld_en` is 1, the register named by `ld_sel` takes a new value on the next clock. Codes 0 to 3 select source X, source Y, destination X and destination Y, and each takes `bus_in[10:0]`. Code 4 selects the step count, which takes all of `bus_in`. Codes 5 to 7 change nothing.
- R3: Each axis owns an op field, `axis_op[2*i+1:2*i]`, where i is the axis code from R2. On a step cycle, op value 1 adds one to that axis.
- R4: On a step cycle, op value 2 subtracts one from that axis.
- R5: Op values 0 and 3 leave the axis unchanged on a step cycle.
- R6: Coordinates wrap modulo 2048. Adding one to 2047 gives 0, and subtracting one from 0 gives 2047.
- R7: `src_addr` equals source Y times 2048 plus source X, and `dst_addr` is formed the same way from the destination coordinates.
- R8: A step cycle is a cycle in which `go` is 1 and `done` is 0. Each step cycle lowers the count by one. `done` is 1 exactly when the count is 0, so after loading N the flag rises after the Nth step cycle, and loading 0 raises it at once.
- R9: While `done` is 1, `go` has no effect on any coordinate or on the count.
- R10: A load wins over a step. A register that is loaded in a step cycle takes the bus value, while the other registers still step.
- R11: When `rd_oe` is 1, `bus_out` shows the register named by `rd_sel`, zero-extended, using the codes of R2. Codes 5 to 7 read 0. When `rd_oe` is 0, `bus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Load target code |
| bus_in | input | 16 | Load data |
| go | input | 1 | Step request |
| axis_op | input | 8 | Two-bit step op for each of the four axes |
| rd_oe | input | 1 | Readback enable |
| rd_sel | input | 3 | Readback target code |
| bus_out | output | 16 | Readback data |
| src_addr | output | 22 | Source linear pixel address |
| dst_addr | output | 22 | Destination linear pixel address |
| done | output | 1 | Step count exhausted |

## Verification
Each axis in turn is walked upward through more than its full 2048-value range while a neighbouring axis is walked downward at the same time. This exposes a wrong wrap at either edge, a swapped op encoding, and ops that leak across to the wrong axis. Step runs are followed by extra `go` cycles to show where `done` rises and that nothing moves afterwards. A load placed in the same cycle as a step separates load priority from stepping. Every readback code is tried with the output enable both on and off, and the unused load codes are tried to show they disturb nothing.

// File: rtl/pixaddr_pkg.sv
package pixaddr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_DEC   = 2'd2,
        OP_HOLDX = 2'd3
    } step_op_e;

    localparam int NUM_AXES = 4;
    localparam logic [2:0] SEL_SRC_X = 3'd0;
    localparam logic [2:0] SEL_SRC_Y = 3'd1;
    localparam logic [2:0] SEL_DST_X = 3'd2;
    localparam logic [2:0] SEL_DST_Y = 3'd3;
    localparam logic [2:0] SEL_COUNT = 3'd4;
endpackage

// File: rtl/pixaddr_axis.sv
module pixaddr_axis #(
    parameter int COORD_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic [COORD_W-1:0]    ld_val,
    input  logic                  adv,
    input  pixaddr_pkg::step_op_e op,
    output logic [COORD_W-1:0]    coord
);
    import pixaddr_pkg::*;

    typedef struct packed {
        logic [COORD_W-1:0] coord;
    } axis_st_t;

    axis_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.coord = ld_val;
        end else if (adv) begin
            case (op)
                OP_INC:  st_d.coord = st_q.coord + 1'b1;
                OP_DEC:  st_d.coord = st_q.coord - 1'b1;
                default: st_d.coord = st_q.coord;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coord = st_q.coord;

    // R3
    axis_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv && !ld && op == OP_INC))
            |-> coord == COORD_W'($past(coord) + 1'b1));

    // R4
    axis_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv && !ld && op == OP_DEC))
            |-> coord == COORD_W'($past(coord) - 1'b1));

    // R5
    axis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ld && (op == OP_HOLD || op == OP_HOLDX)))
            |-> $stable(coord));
endmodule

// File: rtl/pixaddr_stepcnt.sv
module pixaddr_stepcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             go,
    output logic             adv,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign done = (st_q.cnt == '0);
    assign adv  = go && !done;

    always_comb begin
        st_d = st_q;
        if (ld)       st_d.cnt = ld_val;
        else if (adv) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R8
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(go && !done && !ld))
            |-> cnt == CNT_W'($past(cnt) - 1'b1));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ld) |=> done);
endmodule

// File: rtl/pixaddr_readmux.sv
module pixaddr_readmux #(
    parameter int COORD_W = 11,
    parameter int CNT_W   = 16,
    parameter int BUS_W   = 16
) (
    input  logic [pixaddr_pkg::NUM_AXES-1:0][COORD_W-1:0] coords,
    input  logic [CNT_W-1:0]                              cnt,
    input  logic                                          oe,
    input  logic [2:0]                                    sel,
    output logic [BUS_W-1:0]                              bus
);
    import pixaddr_pkg::*;

    always_comb begin
        bus = '0;
        if (oe) begin
            case (sel)
                SEL_SRC_X: bus = BUS_W'(coords[0]);
                SEL_SRC_Y: bus = BUS_W'(coords[1]);
                SEL_DST_X: bus = BUS_W'(coords[2]);
                SEL_DST_Y: bus = BUS_W'(coords[3]);
                SEL_COUNT: bus = BUS_W'(cnt);
                default:   bus = '0;
            endcase
        end
    end
endmodule

// File: rtl/xy_pixel_addr_gen.sv
module xy_pixel_addr_gen #(
    parameter int COORD_W = 11,
    parameter int CNT_W   = 16,
    parameter int BUS_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [2:0]           ld_sel,
    input  logic [BUS_W-1:0]     bus_in,
    input  logic                 go,
    input  logic [7:0]           axis_op,
    input  logic                 rd_oe,
    input  logic [2:0]           rd_sel,
    output logic [BUS_W-1:0]     bus_out,
    output logic [2*COORD_W-1:0] src_addr,
    output logic [2*COORD_W-1:0] dst_addr,
    output logic                 done
);
    import pixaddr_pkg::*;

    localparam int ADDR_W = 2 * COORD_W;

    logic [NUM_AXES-1:0][COORD_W-1:0] coords;
    logic [CNT_W-1:0]                 cnt;
    logic                             adv;
    logic                             cnt_ld;

    assign cnt_ld = ld_en && (ld_sel == SEL_COUNT);

    pixaddr_stepcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (bus_in[CNT_W-1:0]),
        .go     (go),
        .adv    (adv),
        .done   (done),
        .cnt    (cnt)
    );

    for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
        pixaddr_axis #(.COORD_W(COORD_W)) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_en && (ld_sel == 3'(i))),
            .ld_val (bus_in[COORD_W-1:0]),
            .adv    (adv),
            .op     (step_op_e'(axis_op[2*i +: 2])),
            .coord  (coords[i])
        );
    end

    pixaddr_readmux #(.COORD_W(COORD_W), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_rd (
        .coords (coords),
        .cnt    (cnt),
        .oe     (rd_oe),
        .sel    (rd_sel),
        .bus    (bus_out)
    );

    assign src_addr = ADDR_W'({coords[1], coords[0]});
    assign dst_addr = ADDR_W'({coords[3], coords[2]});

    // R9
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go && !ld_en) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

// File: tb/sim_xy_pixel_addr_gen.sv
module sim_xy_pixel_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ld_en = 0;
    logic [2:0]  ld_sel = 0;
    logic [15:0] bus_in = 0;
    logic        go = 0;
    logic [7:0]  axis_op = 0;
    logic        rd_oe = 0;
    logic [2:0]  rd_sel = 0;
    logic [15:0] bus_out;
    logic [21:0] src_addr, dst_addr;
    logic        done;

    int nvec = 0;
    int nbad = 0;
    int mx [4];
    int mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    xy_pixel_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .bus_in(bus_in), .go(go), .axis_op(axis_op), .rd_oe(rd_oe),
        .rd_sel(rd_sel), .bus_out(bus_out), .src_addr(src_addr),
        .dst_addr(dst_addr), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk({req, " src_addr (R7)"}, int'(src_addr), mx[1] * 2048 + mx[0]);
        chk({req, " dst_addr (R7)"}, int'(dst_addr), mx[3] * 2048 + mx[2]);
        chk({req, " done (R8)"}, int'(done), (mcnt == 0) ? 1 : 0);
    endtask

    // one clock: drive at negedge, update model, check at the following negedge
    task automatic cyc(input bit l, input int sel, input int val, input bit g,
                       input logic [7:0] ops, input string req);
        bit adv;
        ld_en = l; ld_sel = 3'(sel); bus_in = 16'(val); go = g; axis_op = ops;
        adv = g && (mcnt != 0);
        for (int i = 0; i < 4; i++) begin
            if (l && sel == i) mx[i] = val % 2048;
            else if (adv) begin
                if (ops[2*i +: 2] == 2'd1) mx[i] = (mx[i] + 1) % 2048;
                else if (ops[2*i +: 2] == 2'd2) mx[i] = (mx[i] + 2047) % 2048;
            end
        end
        if (l && sel == 4) mcnt = val;
        else if (adv) mcnt = mcnt - 1;
        @(posedge clk);
        @(negedge clk);
        ld_en = 0; go = 0; axis_op = 0;
        chk_outs(req);
    endtask

    task automatic readback_all(input string req);
        for (int s = 0; s < 8; s++) begin
            int exp;
            rd_sel = 3'(s);
            rd_oe = 1;
            exp = (s < 4) ? mx[s] : (s == 4 ? mcnt : 0);
            #1;
            chk({req, " readback oe=1 (R11)"}, int'(bus_out), exp);
            rd_oe = 0;
            #1;
            chk({req, " readback oe=0 (R11)"}, int'(bus_out), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mx[i] = 0;
        mcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk_outs("R1 reset");
        readback_all("R1 reset");

        // R2: edge loads on each axis, upper bus bits ignored
        for (int a = 0; a < 4; a++) begin
            cyc(1, a, 16'hF800 | (2047 - a), 0, 8'h00, "R2 load");
            cyc(1, a, a * 500 + 1, 0, 8'h00, "R2 load");
        end
        readback_all("R2 after load");

        // R3 R4 R6: full walk of each axis upward, neighbour downward
        for (int a = 0; a < 4; a++) begin
            int b = (a + 1) % 4;
            logic [7:0] ops = 0;
            ops[2*a +: 2] = 2'd1;
            ops[2*b +: 2] = 2'd2;
            cyc(1, a, 2040, 0, 8'h00, "R6 preset");
            cyc(1, b, 5, 0, 8'h00, "R6 preset");
            cyc(1, 4, 2060, 0, 8'h00, "R8 count load");
            for (int k = 0; k < 2060; k++) cyc(0, 0, 0, 1, ops, "R3 R4 R6 walk");
            // R9: further go has no effect
            for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, ops, "R9 frozen");
            readback_all("R9 frozen");
        end

        // R5: hold codes 0 and 3 on every axis
        cyc(1, 4, 6, 0, 8'h00, "R8 count load");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 8'h00, "R5 hold 0");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 8'hFF, "R5 hold 3");

        // R8: zero load raises done at once; short runs of length 1..5
        cyc(1, 4, 0, 0, 8'h00, "R8 zero load");
        for (int n = 1; n <= 5; n++) begin
            cyc(1, 4, n, 0, 8'h00, "R8 count load");
            for (int k = 0; k < n + 2; k++) cyc(0, 0, 0, 1, 8'h55, "R8 run");
        end

        // R10: load in a step cycle wins on its target, others still step
        cyc(1, 4, 10, 0, 8'h00, "R8 count load");
        cyc(1, 0, 777, 1, 8'h55, "R10 load vs step");
        cyc(1, 3, 3, 1, 8'hAA, "R10 load vs step");
        cyc(1, 4, 20, 1, 8'h55, "R10 count load vs step");
        readback_all("R10");

        // R2: unused load codes change nothing
        for (int s = 5; s < 8; s++) cyc(1, s, 16'h1234, 0, 8'h00, "R2 unused code");
        readback_all("R2 unused code");

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule